// File: doc/BRIEF.md
# Gated retriggerable one-shot timer

This block is a clocked pulse generator that behaves like a retriggerable monostable. It has two trigger inputs of opposite polarity and an active-low clear. Each trigger input only acts while the other input is in its enabling state. The clear input forces the output low and can also start a pulse when it is released. All three inputs may come from asynchronous sources, so each passes through a multi-flop synchronizer before any edge is detected.

The pulse length in clock cycles is the product of two unsigned operands. They play the part of the resistor and the capacitor of an analog timing network. Both operands are captured when a pulse starts or restarts, so the running count is fixed from that moment. A qualifying edge during a pulse reloads the full length from that edge. The output then stays high for the time already elapsed plus one full length. A complementary output is provided alongside the pulse.

Top module: `oneshot_retrig`

## Requirements
- R1: With `trig_lo_i` low and `clr_n_i` high, a low-to-high change on `trig_hi_i` starts a pulse.
- R2: With `trig_hi_i` high and `clr_n_i` high, a high-to-low change on `trig_lo_i` starts a pulse.
- R3: With `trig_lo_i` low and `trig_hi_i` high, a low-to-high change on `clr_n_i` starts a pulse.
- R4: While the synchronized `clr_n_i` is low, `pulse_o` is low. Dropping it mid-pulse ends the pulse, and a trigger edge seen while it is low fires nothing.
- R5: An edge on `trig_hi_i` while `trig_lo_i` is high, or on `trig_lo_i` while `trig_hi_i` is low, fires no pulse.
- R6: A qualifying edge during a pulse reloads the full length. The total high time equals the cycles from the first trigger to the retrigger plus one full length.
- R7: A pulse lasts exactly `dur_r_i * dur_c_i` clock cycles. A trigger whose product is zero is ignored.
- R8: `pulse_n_o` is always the inverse of `pulse_o`. After reset `pulse_o` is low.
- R9: Changing `dur_r_i` or `dur_c_i` during a pulse does not change the length of that pulse.
- R10: `pulse_o` goes high on the third rising clock edge after an input change, counted from the first edge that samples the change. This is two synchronizer stages plus the count register. A clear reaches the output with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_lo_i | input | 1 | Active-low trigger (fires on falling edge) |
| trig_hi_i | input | 1 | Active-high trigger (fires on rising edge) |
| clr_n_i | input | 1 | Active-low clear; its rising edge can also fire |
| dur_r_i | input | R_W | First duration operand |
| dur_c_i | input | C_W | Second duration operand |
| pulse_o | output | 1 | One-shot pulse |
| pulse_n_o | output | 1 | Inverse of `pulse_o` |

## Verification
The bench builds the block with its defaults: two synchronizer stages and 8-bit operands. Products from 0 up to a few tens of cycles can then be chosen freely, so every pulse finishes inside a short window. The zero-product case is reachable by setting either operand to zero. Because the products are short, the bench can count the latency and width of each pulse exactly. It can also overlap a retrigger or a clear with a pulse at a chosen cycle and predict the result.

// File: rtl/oneshot_retrig.sv
module oneshot_retrig #(
  parameter int SYNC_STAGES = 2,
  parameter int R_W = 8,
  parameter int C_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_lo_i,
  input  logic           trig_hi_i,
  input  logic           clr_n_i,
  input  logic [R_W-1:0] dur_r_i,
  input  logic [C_W-1:0] dur_c_i,
  output logic           pulse_o,
  output logic           pulse_n_o
);
  localparam int DUR_W = R_W + C_W;
  // bit 0: active-low trigger, bit 1: active-high trigger, bit 2: clear
  localparam logic [2:0] IDLE = 3'b101;

  logic [2:0]       sync_q [SYNC_STAGES];
  logic [2:0]       prev_q;
  logic [DUR_W-1:0] cnt_q;
  logic [DUR_W-1:0] dur;
  logic [2:0]       cur;
  logic             fire;

  assign cur = sync_q[SYNC_STAGES-1];
  assign dur = DUR_W'(dur_r_i) * DUR_W'(dur_c_i);

  assign fire = cur[2] & (
      (cur[1] & ~prev_q[1] & ~cur[0])              |
      (~cur[0] & prev_q[0] & cur[1])               |
      (~prev_q[2] & ~cur[0] & cur[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE;
      prev_q <= IDLE;
    end else begin
      sync_q[0] <= {clr_n_i, trig_hi_i, trig_lo_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!cur[2])          cnt_q <= '0;
    else if (fire && dur != 0) cnt_q <= dur;
    else if (cnt_q != 0)       cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o   = (cnt_q != 0);
  assign pulse_n_o = ~pulse_o;
endmodule

// File: rtl/oneshot_retrig_chk.sv
module oneshot_retrig_chk #(
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_s,
  input logic             fire,
  input logic [DUR_W-1:0] dur,
  input logic [DUR_W-1:0] cnt_q,
  input logic             pulse_o,
  input logic             pulse_n_o
);
  AST_CLR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n) !clr_s |=> !pulse_o); // R4
  AST_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse_o) |-> $past(fire)); // R5
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n) (fire && clr_s && dur != 0) |=> cnt_q == $past(dur)); // R6
  AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (fire && dur == 0 && cnt_q == 0) |=> !pulse_o); // R7
  AST_STEADY_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (pulse_o && clr_s && !fire) |=> cnt_q == $past(cnt_q) - 1'b1); // R9
  AST_OUT_INVERSE: assert property (@(posedge clk) disable iff (!rst_n) pulse_n_o != pulse_o); // R8
endmodule

bind oneshot_retrig oneshot_retrig_chk #(.DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_s(cur[2]), .fire(fire), .dur(dur),
  .cnt_q(cnt_q), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o));

// File: tb/oneshot_retrig_bench.sv
module oneshot_retrig_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic a = 1, b = 0, c = 1;
  logic [7:0] r = 0, k = 0;
  logic q, qn;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_retrig u_oneshot_retrig (
    .clk(clk), .rst_n(rst_n), .trig_lo_i(a), .trig_hi_i(b), .clr_n_i(c),
    .dur_r_i(r), .dur_c_i(k), .pulse_o(q), .pulse_n_o(qn));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk); a = 1; b = 0; c = 1;
    repeat (40) @(negedge clk);
  endtask

  task automatic measure(output int lat, output int width);
    lat = 0; width = 0;
    while (!q && lat < 60) begin @(negedge clk); lat++; end
    if (q) begin
      width = 1;
      @(negedge clk);
      while (q && width < 200) begin width++; @(negedge clk); end
    end
  endtask

  task automatic t_reset();
    check("R8 reset q", q, 0);
    check("R8 reset qn", qn, 1);
  endtask

  task automatic t_trig_b();
    int lat, w;
    @(negedge clk); a = 0; r = 3; k = 4;
    repeat (5) @(negedge clk);
    b = 1;
    measure(lat, w);
    check("R10 latency", lat, 3);
    check("R1 width", w, 12);
    check("R7 width product", w, 3 * 4);
    go_idle();
  endtask

  task automatic t_trig_a();
    int lat, w;
    @(negedge clk); b = 1; r = 2; k = 5;
    repeat (5) @(negedge clk);
    a = 0;
    measure(lat, w);
    check("R2 latency", lat, 3);
    check("R2 width", w, 10);
    go_idle();
  endtask

  task automatic t_trig_clr();
    int lat, w;
    @(negedge clk); c = 0; r = 7; k = 1;
    repeat (4) @(negedge clk);
    a = 0; b = 1;
    repeat (5) @(negedge clk);
    check("R4 no pulse while clear low", q, 0);
    c = 1;
    measure(lat, w);
    check("R3 latency", lat, 3);
    check("R3 width", w, 7);
    go_idle();
  endtask

  task automatic t_gated();
    int lat, w;
    @(negedge clk); a = 1; r = 3; k = 3;
    repeat (4) @(negedge clk);
    b = 1;
    measure(lat, w);
    check("R5 rise on hi-trig with lo-trig high", w, 0);
    @(negedge clk); a = 0; b = 0;
    repeat (4) @(negedge clk);
    a = 1; repeat (4) @(negedge clk);
    a = 0;
    measure(lat, w);
    check("R5 fall on lo-trig with hi-trig low", w, 0);
    go_idle();
  endtask

  task automatic t_clear_mid();
    int lo = 0;
    @(negedge clk); a = 0; r = 10; k = 3;
    repeat (4) @(negedge clk);
    b = 1;
    repeat (6) @(negedge clk);
    check("R4 pulse running", q, 1);
    c = 0;
    repeat (2) @(negedge clk);
    check("R10 clear latency, still high", q, 1);
    @(negedge clk);
    check("R4 clear ends pulse", q, 0);
    b = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (q) lo++; end
    check("R4 stays low", lo, 0);
    b = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (q) lo++; end
    check("R4 trigger during clear ignored", lo, 0);
    b = 0;
    go_idle();
  endtask

  task automatic t_retrig();
    int lat, w;
    @(negedge clk); a = 0; r = 4; k = 4;
    repeat (4) @(negedge clk);
    fork
      measure(lat, w);
      begin
        b = 1;
        repeat (3) @(negedge clk); b = 0;
        repeat (5) @(negedge clk); b = 1;
      end
    join
    check("R6 retrigger width", w, 8 + 16);
    go_idle();
  endtask

  task automatic t_zero();
    int lat, w;
    @(negedge clk); a = 0; r = 0; k = 9;
    repeat (4) @(negedge clk);
    b = 1;
    measure(lat, w);
    check("R7 zero product ignored", w, 0);
    go_idle();
  endtask

  task automatic t_operand_change();
    int lat, w;
    @(negedge clk); a = 0; r = 4; k = 5;
    repeat (4) @(negedge clk);
    fork
      measure(lat, w);
      begin
        b = 1;
        repeat (6) @(negedge clk); r = 1; k = 1;
      end
    join
    check("R9 width unaffected", w, 20);
    check("R8 qn inverse after pulse", qn, 1);
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_trig_b();
    t_trig_a();
    t_trig_clr();
    t_gated();
    t_clear_mid();
    t_retrig();
    t_zero();
    t_operand_change();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule